// File: doc/BRIEF.md
# Scrambling Wrapper for an Untrusted Storage Unit

This block sits between trusted logic and a storage unit that cannot be trusted, such as a small buffer memory bought in from outside. The wrapped unit is expected only to hold words and return them unchanged. Every word written through the wrapper is XORed with a pad from an internal pseudo-random generator before it reaches the unit, so a chosen data pattern never reaches the unit in the form it was written. The pad used for each address is kept in a trusted array inside the wrapper. On a read, the scrambled word that the unit returns is XORed with that stored pad, which gives back the original value.

The generator is a Galois LFSR that cannot reach the all-zero state, so no write is ever passed through unchanged. It loads from a seed input while reset is held. It moves to its next state once for each accepted write and holds in every other cycle. The unit connects through plain write and read strobes. It must answer a read one clock after the request, and on a read and write to the same address in the same cycle it must return the old contents.

Top module: `scramble_wrap`

## Requirements
- R1: In the cycle `wr_valid` is high, `unit_wr_en` is high, `unit_wr_addr` equals `wr_addr`, and `unit_wr_data` equals `wr_data` XOR the current pad. All three are combinational, with one XOR level on the data.
- R2: While `rst` is high, the pad loads `seed`. A `seed` of zero loads the value 1 instead. The pad is never zero.
- R3: After each clock edge with `wr_valid` high, the pad becomes `(pad >> 1) ^ (pad[0] ? PAD_POLY : 0)`, with `PAD_POLY` = 32'h80200003 by default. After an edge without a write, the pad keeps its value.
- R4: A request with `rd_req` high is sent to the unit in the same cycle (`unit_rd_en`, `unit_rd_addr`). `rd_valid` is high for exactly one cycle, two clock edges after the request edge, and `rd_data` carries the response in that cycle.
- R5: `rd_data` equals the last plaintext written to that address. This holds no matter how many writes to other addresses have advanced the pad since then.
- R6: A read and a write to the same address at the same edge returns the value held before that write.
- R7: `rd_valid` is low after reset and in every cycle that no request two edges earlier accounts for.
- R8: Whenever `wr_valid` is high, `unit_wr_data` differs from `wr_data`.
- R9: A second write to an address is stored with the newer pad, and a read afterwards returns the newer plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the seed |
| seed | input | DATA_W | Start value for the pad generator |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Plaintext write data |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read response valid (registered) |
| rd_data | output | DATA_W | Unscrambled read data (registered) |
| unit_wr_en | output | 1 | Write strobe to the wrapped unit |
| unit_wr_addr | output | ADDR_W | Write address to the wrapped unit |
| unit_wr_data | output | DATA_W | Scrambled write data to the wrapped unit |
| unit_rd_en | output | 1 | Read strobe to the wrapped unit |
| unit_rd_addr | output | ADDR_W | Read address to the wrapped unit |
| unit_rd_data | input | DATA_W | Scrambled word returned by the unit one cycle after its read strobe |

## Verification
A write and a read can hit the same address at the same edge. In that cycle the trusted pad array and the wrapped unit are both being overwritten while they are being read. The bench provokes this by writing a known word, then raising both strobes for that address together with a different word. It judges the result by whether the response two edges later is the first word. A response that came back as the second word, or as the old word unscrambled with the new pad, would show that the pad array and the unit disagree on read-first ordering. A final read then confirms that the second word was stored.

// File: rtl/scramble_pkg.sv
package scramble_pkg;
  parameter int unsigned DEF_DATA_W = 32;
  parameter int unsigned DEF_ADDR_W = 4;
  parameter logic [31:0] DEF_POLY   = 32'h8020_0003;
endpackage

// File: rtl/pad_lfsr.sv
module pad_lfsr #(
  parameter int unsigned          WIDTH = 32,
  parameter logic [WIDTH-1:0]     POLY  = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] seed,
  input  logic             advance,
  output logic [WIDTH-1:0] pad
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nx;

  // Galois step; POLY has its top bit set, so a nonzero state stays nonzero
  always_comb begin
    state_nx = state_q >> 1;
    if (state_q[0]) state_nx = state_nx ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= (seed == '0) ? ONE : seed;
    else if (advance) state_q <= state_nx;
  end

  assign pad = state_q;
endmodule

// File: rtl/pad_store.sv
module pad_store #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // read-first single clock RAM, same ordering the wrapped unit must follow
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/scramble_wrap.sv
module scramble_wrap
  import scramble_pkg::*;
#(
  parameter int unsigned       DATA_W   = DEF_DATA_W,
  parameter int unsigned       ADDR_W   = DEF_ADDR_W,
  parameter logic [DATA_W-1:0] PAD_POLY = DEF_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] seed,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              unit_wr_en,
  output logic [ADDR_W-1:0] unit_wr_addr,
  output logic [DATA_W-1:0] unit_wr_data,
  output logic              unit_rd_en,
  output logic [ADDR_W-1:0] unit_rd_addr,
  input  logic [DATA_W-1:0] unit_rd_data
);
  logic [DATA_W-1:0] pad_q;
  logic [DATA_W-1:0] pad_rd;
  logic              rd_pend_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  pad_lfsr #(.WIDTH(DATA_W), .POLY(PAD_POLY)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .seed   (seed),
    .advance(wr_valid),
    .pad    (pad_q)
  );

  pad_store #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_pads (
    .clk  (clk),
    .we   (wr_valid),
    .waddr(wr_addr),
    .wdata(pad_q),
    .re   (rd_req),
    .raddr(rd_addr),
    .rdata(pad_rd)
  );

  // write path: pad register feeds a single XOR level
  assign unit_wr_en   = wr_valid;
  assign unit_wr_addr = wr_addr;
  assign unit_wr_data = wr_data ^ pad_q;
  assign unit_rd_en   = rd_req;
  assign unit_rd_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_pend_q  <= rd_req;
      rd_valid_q <= rd_pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_pend_q) rd_data_q <= unit_rd_data ^ pad_rd;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/scramble_wrap_chk.sv
module scramble_wrap_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              unit_wr_en,
  input logic [ADDR_W-1:0] unit_wr_addr,
  input logic [DATA_W-1:0] unit_wr_data,
  input logic              unit_rd_en,
  input logic [ADDR_W-1:0] unit_rd_addr,
  input logic [DATA_W-1:0] pad_q
);
  AST_WR_FORWARD: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (unit_wr_en && unit_wr_addr == wr_addr)); // R1

  AST_PAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pad_q != '0); // R2

  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(pad_q)); // R3

  AST_RD_FORWARD: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (unit_rd_en && unit_rd_addr == rd_addr)); // R4

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    unit_rd_en |=> ##1 rd_valid); // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rd_valid); // R7

  AST_NEVER_PLAIN: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> unit_wr_data != wr_data); // R8
endmodule

bind scramble_wrap scramble_wrap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_valid    (rd_valid),
  .unit_wr_en  (unit_wr_en),
  .unit_wr_addr(unit_wr_addr),
  .unit_wr_data(unit_wr_data),
  .unit_rd_en  (unit_rd_en),
  .unit_rd_addr(unit_rd_addr),
  .pad_q       (pad_q)
);

// File: tb/scramble_wrap_bench.sv
module scramble_wrap_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned NW = 1 << AW;
  localparam logic [DW-1:0] POLY = 32'h8020_0003;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] seed = 32'h1234_5678;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          unit_wr_en;
  logic [AW-1:0] unit_wr_addr;
  logic [DW-1:0] unit_wr_data;
  logic          unit_rd_en;
  logic [AW-1:0] unit_rd_addr;
  logic [DW-1:0] unit_rd_data = '0;

  logic [DW-1:0] unit_mem [NW];
  logic [DW-1:0] ref_mem  [NW];
  logic [DW-1:0] exp_pad;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scramble_wrap u_scramble_wrap (
    .clk(clk), .rst(rst), .seed(seed),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .unit_wr_en(unit_wr_en), .unit_wr_addr(unit_wr_addr), .unit_wr_data(unit_wr_data),
    .unit_rd_en(unit_rd_en), .unit_rd_addr(unit_rd_addr), .unit_rd_data(unit_rd_data)
  );

  // stand-in untrusted storage: read-first, one cycle read latency
  always @(posedge clk) begin
    if (unit_wr_en) unit_mem[unit_wr_addr] <= unit_wr_data;
    if (unit_rd_en) unit_rd_data <= unit_mem[unit_rd_addr];
  end

  function automatic logic [DW-1:0] step(input logic [DW-1:0] p);
    return (p >> 1) ^ (p[0] ? POLY : '0);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [DW-1:0] s);
    @(negedge clk);
    seed = s; rst = 1'b1; wr_valid = 1'b0; rd_req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    exp_pad = (s == '0) ? 32'd1 : s;
    check("R7 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    check("R1 scrambled data", unit_wr_data, d ^ exp_pad);
    check("R1 write strobe", {31'd0, unit_wr_en}, 32'd1);
    checks++;
    if (unit_wr_data === d) begin
      fails++;
      $display("FAIL R8 plaintext reached unit actual=%h expected!=%h", unit_wr_data, d);
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
    ref_mem[a] = d;
    exp_pad = step(exp_pad);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_req = 1'b0;
    @(negedge clk);
    check({tag, " early valid"}, {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    check({tag, " valid"}, {31'd0, rd_valid}, 32'd1);
    check({tag, " data"}, rd_data, exp);
    @(negedge clk);
    check({tag, " single pulse"}, {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_seed_load;
    do_reset(32'h1234_5678);
    do_write(4'd0, 32'hAAAA_0000); // R2: first pad equals seed
    do_reset(32'h0);
    do_write(4'd1, 32'h0000_0000); // R2: zero seed gives pad 1
    check("R2 zero seed pad", ref_mem[1] ^ 32'd1, 32'd1);
  endtask

  task automatic t_pad_hold;
    do_reset(32'hCAFE_F00D);
    do_write(4'd2, 32'h1111_1111);
    repeat (5) @(negedge clk); // R3: idle cycles must not advance the pad
    do_write(4'd3, 32'h2222_2222);
    do_read(4'd2, 32'h1111_1111, "R4 basic read");
    do_write(4'd4, 32'h3333_3333); // R3: reads do not advance the pad
  endtask

  task automatic t_old_pad;
    do_write(4'd5, 32'hDEAD_BEEF);
    for (int i = 0; i < 20; i++) do_write(4'(6 + (i % 8)), 32'(i * 32'h0101_0101));
    do_read(4'd5, 32'hDEAD_BEEF, "R5 stored pad");
  endtask

  task automatic t_same_cycle;
    do_write(4'd14, 32'h5555_AAAA);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd14; wr_data = 32'h0F0F_0F0F;
    rd_req = 1'b1; rd_addr = 4'd14;
    @(posedge clk); #1;
    wr_valid = 1'b0; rd_req = 1'b0;
    exp_pad = step(exp_pad);
    @(negedge clk); @(negedge clk);
    check("R6 read-first valid", {31'd0, rd_valid}, 32'd1);
    check("R6 read-first data", rd_data, 32'h5555_AAAA);
    do_read(4'd14, 32'h0F0F_0F0F, "R6 new value");
  endtask

  task automatic t_overwrite;
    do_write(4'd15, 32'h1357_9BDF);
    do_write(4'd15, 32'h2468_ACE0);
    do_read(4'd15, 32'h2468_ACE0, "R9 overwrite");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < int'(NW); i++) do_write(4'(i), 32'hA5A5_0000 + 32'(i * 7));
    for (int i = 0; i < int'(NW); i++) do_read(4'(i), 32'hA5A5_0000 + 32'(i * 7), "R5 sweep");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 idle valid", {31'd0, rd_valid}, 32'd0);
    end
  endtask

  initial begin
    fork
      begin
        t_seed_load();
        t_pad_hold();
        t_old_pad();
        t_same_cycle();
        t_overwrite();
        t_sweep();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule